// File: doc/BRIEF.md
# Dual-Source MAC Packet Multiplexer

This block lets two packet sources share a single 64-bit streaming Ethernet MAC. One is a low-rate admin source and the other a bulk-data source. On the transmit side a packet-level arbiter connects one source at a time to the MAC. It switches only between packets, takes turns when both sources are waiting, and serves a lone requester at once.

On the receive side, whole frames from the MAC are staged in a frame buffer. A frame becomes visible downstream only when its last beat arrives with the good-status flag set. Frames that carry a CRC error, that do not fit in the buffer, or that have no destination are discarded whole. A route mask sampled with the first beat of each frame picks the admin channel, the bulk channel, or both. When both are picked, each beat is handed over only when both channels accept it together.

Everything runs in the MAC clock domain with a synchronous active-high reset.

Top module: `mac_share_mux`

## Requirements
- R1: When both sources hold a pending packet at a packet boundary, the grant goes to the source that did not send the previous packet. After reset, the admin source wins a tie.
- R2: When the MAC is idle and only one source is valid, that source's beat is presented on the MAC port in the same cycle, even if it also sent the previous packet.
- R3: From a packet's first accepted beat until its last-flagged beat, every MAC beat comes from the same source, and the other source's ready stays 0.
- R4: Transmit beats pass through unchanged in data, keep and last. This includes a partial keep on the final beat, where keep bit i qualifies byte lane i (bits 8i+7..8i).
- R5: After the MAC accepts the last beat of a received frame, receive ready is 0 for exactly 2 cycles and 1 in the cycle after that.
- R6: A frame whose status bit is 0 on its last beat is never delivered to either channel.
- R7: No beat of a received frame appears on a channel before the frame's last beat has been accepted from the MAC.
- R8: The route mask is sampled with a frame's first beat: bit 0 selects the admin channel and bit 1 selects the bulk channel. Changes to the mask later in the frame have no effect, and a mask of 00 discards the frame.
- R9: A frame routed to both channels reaches each channel with identical beats in the original order. This holds under any pattern of channel back-pressure.
- R10: Receive ready stays 1 through the body of a frame. A frame longer than the free buffer space is dropped whole, while a frame that exactly fills an empty buffer is delivered.
- R11: Directly after reset, both channel valids and the MAC transmit valid are 0 with no source valid, and receive ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock |
| rst | input | 1 | Synchronous active-high reset |
| adm_tx_data | input | 64 | Admin source transmit data |
| adm_tx_keep | input | 8 | Admin source byte keep |
| adm_tx_last | input | 1 | Admin source last beat of packet |
| adm_tx_valid | input | 1 | Admin source beat valid |
| adm_tx_ready | output | 1 | Admin source beat accepted |
| blk_tx_data | input | 64 | Bulk source transmit data |
| blk_tx_keep | input | 8 | Bulk source byte keep |
| blk_tx_last | input | 1 | Bulk source last beat of packet |
| blk_tx_valid | input | 1 | Bulk source beat valid |
| blk_tx_ready | output | 1 | Bulk source beat accepted |
| mac_tx_data | output | 64 | Data to MAC |
| mac_tx_keep | output | 8 | Byte keep to MAC |
| mac_tx_last | output | 1 | Last beat to MAC |
| mac_tx_valid | output | 1 | Beat valid to MAC |
| mac_tx_ready | input | 1 | MAC accepts beat |
| mac_rx_data | input | 64 | Received data from MAC |
| mac_rx_keep | input | 8 | Received byte keep |
| mac_rx_last | input | 1 | Last beat of received frame |
| mac_rx_ok | input | 1 | Frame status with last beat: 1 good, 0 CRC error |
| mac_rx_valid | input | 1 | Received beat valid |
| mac_rx_ready | output | 1 | Block accepts received beat |
| rx_route | input | 2 | Destination mask, bit 0 admin, bit 1 bulk |
| adm_rx_data | output | 64 | Admin channel receive data |
| adm_rx_keep | output | 8 | Admin channel byte keep |
| adm_rx_last | output | 1 | Admin channel last beat |
| adm_rx_valid | output | 1 | Admin channel beat valid |
| adm_rx_ready | input | 1 | Admin channel accepts beat |
| blk_rx_data | output | 64 | Bulk channel receive data |
| blk_rx_keep | output | 8 | Bulk channel byte keep |
| blk_rx_last | output | 1 | Bulk channel last beat |
| blk_rx_valid | output | 1 | Bulk channel beat valid |
| blk_rx_ready | input | 1 | Bulk channel accepts beat |

## Verification
Two things can land in the same clock edge: the commit of a newly completed frame (or the rewind of a rejected one) in the frame buffer, and the pop of an older frame's beat by the channel fanout. The bench provokes this by sending frames back to back while the channel readies toggle pseudo-randomly, so commits, rewinds and pops overlap across many cycles. A scoreboard judges the result: it must see every surviving beat exactly once, in order, on each routed channel and never early. On transmit, a packet-boundary handover coincides with a fresh request from the other source. The monitor judges this from the two sources' valid lines, sampled in that very cycle.

// File: rtl/mac_share_pkg.sv
package mac_share_pkg;

    localparam int DATA_W = 64;
    localparam int KEEP_W = DATA_W / 8;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [KEEP_W-1:0] keep;
        logic              last;
    } beat_t;

    typedef struct packed {
        beat_t             beat;
        logic [NUM_CH-1:0] route;
    } rx_entry_t;

    typedef enum logic [0:0] {
        CH_ADM = 1'b0,
        CH_BLK = 1'b1
    } chan_e;

    function automatic chan_e next_turn(chan_e served);
        return (served == CH_ADM) ? CH_BLK : CH_ADM;
    endfunction

endpackage

// File: rtl/msm_tx_arbiter.sv
module msm_tx_arbiter
    import mac_share_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  beat_t [NUM_CH-1:0]      src_beat,
    input  logic  [NUM_CH-1:0]      src_valid,
    output logic  [NUM_CH-1:0]      src_ready,
    output beat_t                   mac_beat,
    output logic                    mac_valid,
    input  logic                    mac_ready
);

    logic  locked;
    chan_e owner;
    chan_e served;
    chan_e pick;
    chan_e sel;
    logic  fire;

    always_comb begin
        if (src_valid[CH_ADM] && src_valid[CH_BLK]) pick = next_turn(served);
        else if (src_valid[CH_BLK])                 pick = CH_BLK;
        else                                        pick = CH_ADM;
    end

    assign sel       = locked ? owner : pick;
    assign mac_valid = src_valid[sel];
    assign mac_beat  = src_beat[sel];
    assign fire      = mac_valid & mac_ready;

    always_comb begin
        src_ready      = '0;
        src_ready[sel] = mac_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
            owner  <= CH_ADM;
            served <= CH_BLK;
        end else if (fire) begin
            if (mac_beat.last) begin
                locked <= 1'b0;
                served <= sel;
            end else begin
                locked <= 1'b1;
                owner  <= sel;
            end
        end
    end

    p_hold_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !mac_beat.last) |=> (sel == $past(sel)));

    p_alternate_r1: assert property (@(posedge clk) disable iff (rst)
        (fire && mac_beat.last) |=> ((src_valid[CH_ADM] && src_valid[CH_BLK]) -> (sel != $past(sel))));

    p_single_ready_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ready));

endmodule

// File: rtl/msm_rx_frame_buf.sv
module msm_rx_frame_buf
    import mac_share_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int BACKOFF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             in_beat,
    input  logic              in_valid,
    input  logic              in_good,
    input  logic [NUM_CH-1:0] route_in,
    output logic              in_ready,
    output rx_entry_t         head,
    output logic              avail,
    input  logic              pop
);

    localparam int AW    = $clog2(DEPTH);
    localparam int PTR_W = AW + 1;
    localparam int GAP_W = $clog2(BACKOFF + 1);
    localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH);

    rx_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, commit_ptr, rd_ptr;
    logic [PTR_W-1:0]  used;
    logic              full;
    logic              in_frame;
    logic              spoiled;
    logic [NUM_CH-1:0] route_q;
    logic [NUM_CH-1:0] route_cur;
    logic [GAP_W-1:0]  gap;
    logic              acc;
    logic              wr_ok;
    logic              end_ok;

    assign used      = wr_ptr - rd_ptr;
    assign full      = (used == CAP);
    assign in_ready  = (gap == '0);
    assign acc       = in_valid & in_ready;
    assign route_cur = in_frame ? route_q : route_in;
    assign wr_ok     = acc & ~full & ~spoiled;
    assign end_ok    = wr_ok & in_beat.last & in_good & (|route_cur);

    assign avail = (rd_ptr != commit_ptr);
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr[AW-1:0]] <= '{beat: in_beat, route: route_cur};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            commit_ptr <= '0;
            rd_ptr     <= '0;
            in_frame   <= 1'b0;
            spoiled    <= 1'b0;
            route_q    <= '0;
            gap        <= '0;
        end else begin
            if (acc) begin
                if (in_beat.last) begin
                    in_frame <= 1'b0;
                    spoiled  <= 1'b0;
                    gap      <= GAP_W'(BACKOFF);
                    if (end_ok) begin
                        wr_ptr     <= wr_ptr + 1'b1;
                        commit_ptr <= wr_ptr + 1'b1;
                    end else begin
                        wr_ptr <= commit_ptr;
                    end
                end else begin
                    in_frame <= 1'b1;
                    if (!in_frame) route_q <= route_in;
                    if (full || spoiled) spoiled <= 1'b1;
                    else                 wr_ptr  <= wr_ptr + 1'b1;
                end
            end else if (gap != '0) begin
                gap <= gap - 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr - rd_ptr) <= CAP);

    p_commit_behind_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_ptr - rd_ptr) <= (wr_ptr - rd_ptr));

    p_backoff_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && in_beat.last) |=> !in_ready);

    p_pop_only_committed_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> avail);

endmodule

// File: rtl/msm_rx_fanout.sv
module msm_rx_fanout
    import mac_share_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rx_entry_t         head,
    input  logic              avail,
    output logic              pop,
    output beat_t             ch_beat,
    output logic [NUM_CH-1:0] ch_valid,
    input  logic [NUM_CH-1:0] ch_ready
);

    logic [NUM_CH-1:0] ok_vec;

    assign ok_vec  = ~head.route | ch_ready;
    assign pop     = avail & (&ok_vec);
    assign ch_beat = head.beat;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [NUM_CH-1:0] others_ok;
        assign others_ok   = ok_vec | (NUM_CH'(1) << k);
        assign ch_valid[k] = avail & head.route[k] & (&others_ok);
    end

    p_route_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        avail |-> (|head.route));

    p_pop_matches_route_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> ((ch_valid & ch_ready) == head.route));

endmodule

// File: rtl/mac_share_mux.sv
module mac_share_mux
    import mac_share_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int RX_GAP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] adm_tx_data,
    input  logic [KEEP_W-1:0] adm_tx_keep,
    input  logic              adm_tx_last,
    input  logic              adm_tx_valid,
    output logic              adm_tx_ready,
    input  logic [DATA_W-1:0] blk_tx_data,
    input  logic [KEEP_W-1:0] blk_tx_keep,
    input  logic              blk_tx_last,
    input  logic              blk_tx_valid,
    output logic              blk_tx_ready,
    output logic [DATA_W-1:0] mac_tx_data,
    output logic [KEEP_W-1:0] mac_tx_keep,
    output logic              mac_tx_last,
    output logic              mac_tx_valid,
    input  logic              mac_tx_ready,
    input  logic [DATA_W-1:0] mac_rx_data,
    input  logic [KEEP_W-1:0] mac_rx_keep,
    input  logic              mac_rx_last,
    input  logic              mac_rx_ok,
    input  logic              mac_rx_valid,
    output logic              mac_rx_ready,
    input  logic [NUM_CH-1:0] rx_route,
    output logic [DATA_W-1:0] adm_rx_data,
    output logic [KEEP_W-1:0] adm_rx_keep,
    output logic              adm_rx_last,
    output logic              adm_rx_valid,
    input  logic              adm_rx_ready,
    output logic [DATA_W-1:0] blk_rx_data,
    output logic [KEEP_W-1:0] blk_rx_keep,
    output logic              blk_rx_last,
    output logic              blk_rx_valid,
    input  logic              blk_rx_ready
);

    beat_t [NUM_CH-1:0] tx_src;
    logic  [NUM_CH-1:0] tx_valid;
    logic  [NUM_CH-1:0] tx_ready;
    beat_t              tx_out;
    beat_t              rx_in;
    rx_entry_t          rx_head;
    logic               rx_avail;
    logic               rx_pop;
    beat_t              rx_out;
    logic  [NUM_CH-1:0] rx_valid;
    logic  [NUM_CH-1:0] rx_ready;

    assign tx_src[CH_ADM] = '{data: adm_tx_data, keep: adm_tx_keep, last: adm_tx_last};
    assign tx_src[CH_BLK] = '{data: blk_tx_data, keep: blk_tx_keep, last: blk_tx_last};
    assign tx_valid       = {blk_tx_valid, adm_tx_valid};
    assign adm_tx_ready   = tx_ready[CH_ADM];
    assign blk_tx_ready   = tx_ready[CH_BLK];
    assign mac_tx_data    = tx_out.data;
    assign mac_tx_keep    = tx_out.keep;
    assign mac_tx_last    = tx_out.last;

    msm_tx_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .src_beat  (tx_src),
        .src_valid (tx_valid),
        .src_ready (tx_ready),
        .mac_beat  (tx_out),
        .mac_valid (mac_tx_valid),
        .mac_ready (mac_tx_ready)
    );

    assign rx_in = '{data: mac_rx_data, keep: mac_rx_keep, last: mac_rx_last};

    msm_rx_frame_buf #(
        .DEPTH   (RX_DEPTH),
        .BACKOFF (RX_GAP)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_beat  (rx_in),
        .in_valid (mac_rx_valid),
        .in_good  (mac_rx_ok),
        .route_in (rx_route),
        .in_ready (mac_rx_ready),
        .head     (rx_head),
        .avail    (rx_avail),
        .pop      (rx_pop)
    );

    assign rx_ready = {blk_rx_ready, adm_rx_ready};

    msm_rx_fanout u_fan (
        .clk      (clk),
        .rst      (rst),
        .head     (rx_head),
        .avail    (rx_avail),
        .pop      (rx_pop),
        .ch_beat  (rx_out),
        .ch_valid (rx_valid),
        .ch_ready (rx_ready)
    );

    assign adm_rx_data  = rx_out.data;
    assign adm_rx_keep  = rx_out.keep;
    assign adm_rx_last  = rx_out.last;
    assign adm_rx_valid = rx_valid[CH_ADM];
    assign blk_rx_data  = rx_out.data;
    assign blk_rx_keep  = rx_out.keep;
    assign blk_rx_last  = rx_out.last;
    assign blk_rx_valid = rx_valid[CH_BLK];

endmodule

// File: tb/mac_share_mux_test.sv
module mac_share_mux_test;
    import mac_share_pkg::*;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [63:0] adm_tx_data = '0, blk_tx_data = '0, mac_rx_data = '0;
    logic [7:0]  adm_tx_keep = '0, blk_tx_keep = '0, mac_rx_keep = '0;
    logic adm_tx_last = 0, adm_tx_valid = 0, blk_tx_last = 0, blk_tx_valid = 0;
    logic mac_tx_ready = 1, mac_rx_last = 0, mac_rx_ok = 0, mac_rx_valid = 0;
    logic [1:0] rx_route = '0;
    logic adm_rx_ready = 1, blk_rx_ready = 1;
    logic adm_tx_ready, blk_tx_ready, mac_tx_last, mac_tx_valid, mac_rx_ready;
    logic [63:0] mac_tx_data, adm_rx_data, blk_rx_data;
    logic [7:0]  mac_tx_keep, adm_rx_keep, blk_rx_keep;
    logic adm_rx_last, adm_rx_valid, blk_rx_last, blk_rx_valid;

    mac_share_mux #(.RX_DEPTH(DEPTH), .RX_GAP(2)) uut (
        .clk(clk), .rst(rst),
        .adm_tx_data(adm_tx_data), .adm_tx_keep(adm_tx_keep), .adm_tx_last(adm_tx_last),
        .adm_tx_valid(adm_tx_valid), .adm_tx_ready(adm_tx_ready),
        .blk_tx_data(blk_tx_data), .blk_tx_keep(blk_tx_keep), .blk_tx_last(blk_tx_last),
        .blk_tx_valid(blk_tx_valid), .blk_tx_ready(blk_tx_ready),
        .mac_tx_data(mac_tx_data), .mac_tx_keep(mac_tx_keep), .mac_tx_last(mac_tx_last),
        .mac_tx_valid(mac_tx_valid), .mac_tx_ready(mac_tx_ready),
        .mac_rx_data(mac_rx_data), .mac_rx_keep(mac_rx_keep), .mac_rx_last(mac_rx_last),
        .mac_rx_ok(mac_rx_ok), .mac_rx_valid(mac_rx_valid), .mac_rx_ready(mac_rx_ready),
        .rx_route(rx_route),
        .adm_rx_data(adm_rx_data), .adm_rx_keep(adm_rx_keep), .adm_rx_last(adm_rx_last),
        .adm_rx_valid(adm_rx_valid), .adm_rx_ready(adm_rx_ready),
        .blk_rx_data(blk_rx_data), .blk_rx_keep(blk_rx_keep), .blk_rx_last(blk_rx_last),
        .blk_rx_valid(blk_rx_valid), .blk_rx_ready(blk_rx_ready)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- transmit scoreboard ----------------
    beat_t src_q0[$], src_q1[$], tx_exp0[$], tx_exp1[$];
    logic adm_fired = 0, blk_fired = 0;
    bit   in_pkt = 0, have_prev = 0;
    int   pkt_src = 0, prev_src = 0;

    task automatic push_tx_pkt(input int s, input int pid, input int n, input logic [7:0] lastkeep);
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.data = {4'(s + 1), 4'h0, 8'(pid), 16'(i), 32'hC0DE_0000 | 32'(i)};
            b.last = (i == n - 1);
            b.keep = b.last ? lastkeep : 8'hFF;
            if (s == 0) begin src_q0.push_back(b); tx_exp0.push_back(b); end
            else        begin src_q1.push_back(b); tx_exp1.push_back(b); end
        end
    endtask

    initial forever begin
        @(posedge clk); #1;
        if (adm_fired && src_q0.size() > 0) void'(src_q0.pop_front());
        if (src_q0.size() > 0) begin
            adm_tx_valid = 1; {adm_tx_data, adm_tx_keep, adm_tx_last} = src_q0[0];
        end else adm_tx_valid = 0;
    end

    initial forever begin
        @(posedge clk); #1;
        if (blk_fired && src_q1.size() > 0) void'(src_q1.pop_front());
        if (src_q1.size() > 0) begin
            blk_tx_valid = 1; {blk_tx_data, blk_tx_keep, blk_tx_last} = src_q1[0];
        end else blk_tx_valid = 0;
    end

    always @(negedge clk) begin
        adm_fired = adm_tx_valid && adm_tx_ready && !rst;
        blk_fired = blk_tx_valid && blk_tx_ready && !rst;
        if (!rst) begin
            if (!in_pkt && mac_tx_ready && (adm_tx_valid || blk_tx_valid))
                chk(mac_tx_valid, "R2 lone requester presented", 128'(mac_tx_valid), 128'(1));
            if (in_pkt)
                chk(pkt_src == 0 ? !(blk_tx_valid && blk_tx_ready) : !(adm_tx_valid && adm_tx_ready),
                    "R3 other source held off", 128'(pkt_src == 0 ? blk_tx_ready : adm_tx_ready), 128'(0));
            if (mac_tx_valid && mac_tx_ready) begin
                int s;
                beat_t got, want;
                s = int'(mac_tx_data[63:60]) - 1;
                got = '{data: mac_tx_data, keep: mac_tx_keep, last: mac_tx_last};
                if (!in_pkt) begin
                    if (adm_tx_valid && blk_tx_valid && have_prev)
                        chk(s != prev_src, "R1 alternate on tie", 128'(s), 128'(1 - prev_src));
                    pkt_src = s;
                    in_pkt  = 1;
                end else begin
                    chk(s == pkt_src, "R3 grant held in packet", 128'(s), 128'(pkt_src));
                end
                if (s == 0 && tx_exp0.size() > 0)      want = tx_exp0.pop_front();
                else if (s == 1 && tx_exp1.size() > 0) want = tx_exp1.pop_front();
                else want = '0;
                chk(got == want, "R4 tx beat", 128'(got), 128'(want));
                if (mac_tx_last) begin
                    in_pkt = 0; prev_src = s; have_prev = 1;
                end
            end
        end
    end

    // ---------------- receive scoreboard ----------------
    beat_t rx_exp0[$], rx_exp1[$];
    bit    done_f[256];

    always @(negedge clk) begin
        if (!rst) begin
            if (adm_rx_valid && adm_rx_ready) begin
                beat_t got, want;
                got  = '{data: adm_rx_data, keep: adm_rx_keep, last: adm_rx_last};
                want = (rx_exp0.size() > 0) ? rx_exp0.pop_front() : '0;
                chk(got == want, "R9 admin channel beat (R6 R8 drops)", 128'(got), 128'(want));
                chk(done_f[adm_rx_data[55:48]], "R7 admin after last", 128'(0), 128'(1));
            end
            if (blk_rx_valid && blk_rx_ready) begin
                beat_t got, want;
                got  = '{data: blk_rx_data, keep: blk_rx_keep, last: blk_rx_last};
                want = (rx_exp1.size() > 0) ? rx_exp1.pop_front() : '0;
                chk(got == want, "R9 bulk channel beat (R6 R8 drops)", 128'(got), 128'(want));
                chk(done_f[blk_rx_data[55:48]], "R7 bulk after last", 128'(0), 128'(1));
            end
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    bit rand_en = 0;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rand_en) begin
            adm_rx_ready = lfsr[0] | lfsr[3];
            blk_rx_ready = lfsr[5] | lfsr[8];
        end
    end

    task automatic send_frame(input int id, input int n, input logic good, input logic [1:0] route);
        bit deliver;
        deliver = good && (route != 2'b00) && (n <= DEPTH);
        for (int i = 0; i < n; i++) begin
            beat_t b;
            b.data = {8'hA5, 8'(id), 16'(i), 32'(id * 7 + i)};
            b.last = (i == n - 1);
            b.keep = b.last ? 8'(8'hFF >> (i % 8)) : 8'hFF;
            @(posedge clk); #1;
            mac_rx_valid = 1;
            {mac_rx_data, mac_rx_keep, mac_rx_last} = b;
            mac_rx_ok = b.last ? good : 1'b0;
            rx_route  = (i == 0) ? route : ~route;
            if (deliver) begin
                if (route[0]) rx_exp0.push_back(b);
                if (route[1]) rx_exp1.push_back(b);
            end
            @(negedge clk);
            if (i == 0) begin
                while (!mac_rx_ready) @(negedge clk);
            end else begin
                chk(mac_rx_ready, "R10 ready held in frame", 128'(mac_rx_ready), 128'(1));
            end
        end
        done_f[id[7:0]] = 1;
        @(posedge clk); #1;
        mac_rx_valid = 0; mac_rx_last = 0;
        @(negedge clk); chk(!mac_rx_ready, "R5 gap cycle 1", 128'(mac_rx_ready), 128'(0));
        @(negedge clk); chk(!mac_rx_ready, "R5 gap cycle 2", 128'(mac_rx_ready), 128'(0));
        @(negedge clk); chk(mac_rx_ready,  "R5 ready back",  128'(mac_rx_ready), 128'(1));
    endtask

    task automatic wait_tx_idle();
        while (src_q0.size() > 0 || src_q1.size() > 0 || in_pkt) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic wait_rx_idle();
        while (rx_exp0.size() > 0 || rx_exp1.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(!mac_tx_valid, "R11 tx valid idle", 128'(mac_tx_valid), 128'(0));
        chk(mac_rx_ready,  "R11 rx ready",      128'(mac_rx_ready), 128'(1));
        chk(!adm_rx_valid, "R11 adm rx valid",  128'(adm_rx_valid), 128'(0));
        chk(!blk_rx_valid, "R11 blk rx valid",  128'(blk_rx_valid), 128'(0));

        // lone sources, partial keep (R2, R4)
        push_tx_pkt(0, 1, 3, 8'h07);
        wait_tx_idle();
        push_tx_pkt(1, 2, 1, 8'h01);
        wait_tx_idle();
        // contention (R1, R3)
        push_tx_pkt(0, 3, 4, 8'h3F); push_tx_pkt(1, 4, 2, 8'hFF);
        push_tx_pkt(0, 5, 1, 8'h0F); push_tx_pkt(1, 6, 5, 8'h03);
        push_tx_pkt(0, 7, 2, 8'h7F); push_tx_pkt(1, 8, 3, 8'h1F);
        wait_tx_idle();
        // same source back to back (R2)
        push_tx_pkt(0, 9, 2, 8'hFF); push_tx_pkt(0, 10, 3, 8'h01); push_tx_pkt(0, 11, 1, 8'h80);
        wait_tx_idle();
        push_tx_pkt(1, 12, 2, 8'h0F); push_tx_pkt(1, 13, 2, 8'hFF);
        wait_tx_idle();

        // receive routing and drops (R6, R7, R8)
        send_frame(1, 3, 1, 2'b01);
        send_frame(2, 2, 1, 2'b10);
        send_frame(3, 4, 1, 2'b11);
        send_frame(4, 3, 0, 2'b11);
        send_frame(5, 2, 1, 2'b00);
        send_frame(6, 1, 1, 2'b11);
        wait_rx_idle();

        // broadcast under back-pressure (R9)
        rand_en = 1;
        for (int f = 0; f < 24; f++) begin
            while (rx_exp0.size() > 8 || rx_exp1.size() > 8) @(posedge clk);
            send_frame(10 + f, 1 + (f % 4), (f % 5) != 3, 2'((f % 3) + 1));
        end
        rand_en = 0;
        @(posedge clk); #1 adm_rx_ready = 1; blk_rx_ready = 1;
        wait_rx_idle();

        // capacity boundary (R10)
        send_frame(40, DEPTH + 1, 1, 2'b11);
        wait_rx_idle();
        send_frame(41, DEPTH, 1, 2'b11);
        wait_rx_idle();
        send_frame(42, 2, 1, 2'b10);
        wait_rx_idle();

        repeat (20) @(posedge clk);
        chk(tx_exp0.size() == 0 && tx_exp1.size() == 0, "R4 tx all delivered",
            128'(tx_exp0.size() + tx_exp1.size()), 128'(0));
        chk(rx_exp0.size() == 0, "R9 admin all delivered", 128'(rx_exp0.size()), 128'(0));
        chk(rx_exp1.size() == 0, "R9 bulk all delivered",  128'(rx_exp1.size()), 128'(0));
        finish_run();
    end

endmodule